// File: doc/BRIEF.md
# Vetoed Event Timestamp Counter

This block keeps a 64-bit event timestamp for a data acquisition trigger. By default the counter advances on an internal tick that fires once every four system clocks, which gives 10 MHz from a 40 MHz clock. A select bit can switch the counter to the rising edges of an external timestamp clock instead. A veto input freezes the count while it is active. The veto usually comes from the acquisition busy logic, so that dead time is not timestamped.

When a latch event arrives, the current count is copied into a holding register. The latch event is either the internal live trigger pulse or, when a second select bit is set, a rising edge on an external latch input. The holding register is read back 16 bits at a time through four sub-addresses, and each slice is zero-extended into a 24-bit read word. The value stays frozen until the next latch event, so the four reads always form one coherent snapshot. The effective count enable and capture strobe are driven out as registered pulses, so that other acquisition systems can share the same timebase. A synchronous module clear zeroes the counter, the snapshot and the tick phase.

Top module: `evt_timestamp`

## Requirements
- R1: With sel_i[0]=0 and no veto, the counter increments once every 4 clocks. After a clear (or reset) sampled at edge e0, the count after edge ek equals floor(k/4).
- R2: While veto_i is high at a clock edge, the counter keeps its value at that edge.
- R3: With sel_i[0]=1, the counter increments once for each rising edge of ext_clk_i. The increment takes effect at the second clock edge after the edge that first samples the high level. Internal ticks are ignored in this mode.
- R4: With sel_i[1]=0, a high live_trig_i at an edge copies the count held before that edge into the snapshot. With sel_i[1]=1, a synchronized rising edge of ext_latch_i does the capture instead, and live_trig_i has no effect.
- R5: The snapshot does not change between capture events, even while the counter keeps running.
- R6: Reads return their data one clock after rd_addr_i is presented. Addresses 1, 2, 3 and 4 return snapshot bits [15:0], [31:16], [47:32] and [63:48] in rd_data_o[15:0], with rd_data_o[23:16]=0. Every other address returns 0.
- R7: A high clear_i, or an active rst_ni, sets the counter, the snapshot and the tick phase to zero.
- R8: ts_clk_o is high for exactly one clock after each counter increment. ts_latch_o is high for exactly one clock after each capture.
- R9: The count carries across the 16-bit slice boundaries, so a count of 65537 reads back as 1 at address 1 and 1 at address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (40 MHz nominal) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Synchronous module clear |
| ext_clk_i | input | 1 | External timestamp clock, asynchronous |
| ext_latch_i | input | 1 | External timestamp latch, asynchronous |
| veto_i | input | 1 | Count inhibit |
| sel_i | input | 2 | Bit 0: use the external clock; bit 1: use the external latch |
| live_trig_i | input | 1 | Internal live trigger pulse, used as the latch when sel_i[1]=0 |
| rd_addr_i | input | 4 | Read sub-address |
| rd_data_o | output | 24 | Registered read data |
| ts_clk_o | output | 1 | Registered copy of the effective count enable |
| ts_latch_o | output | 1 | Registered copy of the capture strobe |

## Verification
A wrong divider phase or a leaking veto shows up as a snapshot value that is off by one or more ticks. That error is visible on the first read after the next capture. A broken synchronizer or a wrong select decode shows up as a count that does not match the number of external pulses, or as a snapshot that changes on an ignored trigger. It is seen on the next read of address 1. A lost carry or a wrong slice mapping shows up only in the upper read slices, which is why one run counts past 65536. Errors in the mirrored strobes show up as wrong pulse totals on ts_clk_o and ts_latch_o within the same scenario.

// File: rtl/evt_ts_pkg.sv
package evt_ts_pkg;
  localparam int TS_W    = 64;
  localparam int SLICE_W = 16;
  localparam int RD_W    = 24;
  localparam int ADDR_W  = 4;
  localparam int TICK_DIV = 4;
  localparam int SEL_EXT_CLK   = 0;
  localparam int SEL_EXT_LATCH = 1;
endpackage

// File: rtl/ts_edge_sync.sv
module ts_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  assert_rise_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ts_tick_div.sv
module ts_tick_div #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clear_i)        cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  assert_tick_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/ts_core.sv
module ts_core
  import evt_ts_pkg::*;
#(
  parameter int W = TS_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         int_tick_i,
  input  logic         ext_tick_i,
  input  logic         ext_latch_i,
  input  logic         live_trig_i,
  input  logic         veto_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] snap_o,
  output logic         ts_clk_o,
  output logic         ts_latch_o
);
  logic [W-1:0] count_q, snap_q;
  logic src_tick, cnt_en, cap_en;

  assign src_tick = sel_i[SEL_EXT_CLK] ? ext_tick_i : int_tick_i;
  assign cnt_en   = src_tick & ~veto_i & ~clear_i;
  assign cap_en   = (sel_i[SEL_EXT_LATCH] ? ext_latch_i : live_trig_i) & ~clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q    <= '0;
      snap_q     <= '0;
      ts_clk_o   <= 1'b0;
      ts_latch_o <= 1'b0;
    end else begin
      ts_clk_o   <= cnt_en;
      ts_latch_o <= cap_en;
      if (clear_i)     count_q <= '0;
      else if (cnt_en) count_q <= count_q + 1'b1;
      if (clear_i)     snap_q <= '0;
      else if (cap_en) snap_q <= count_q;
    end
  end

  assign snap_o = snap_q;

  assert_veto_freeze_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (veto_i && !clear_i) |=> (count_q == $past(count_q)));
  assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1));
  assert_clear_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_q == '0) && (snap_q == '0));
  assert_snap_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ts_latch_o && $past(!clear_i)) |-> $stable(snap_q));
  assert_strobe_inc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_clk_o |-> (count_q == $past(count_q) + 1'b1));
endmodule

// File: rtl/evt_timestamp.sv
module evt_timestamp
  import evt_ts_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              ext_clk_i,
  input  logic              ext_latch_i,
  input  logic              veto_i,
  input  logic [1:0]        sel_i,
  input  logic              live_trig_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [RD_W-1:0]   rd_data_o,
  output logic              ts_clk_o,
  output logic              ts_latch_o
);
  localparam int N_SLICE = TS_W / SLICE_W;

  logic int_tick, ext_tick, ext_latch;
  logic [TS_W-1:0] snap;
  logic [RD_W-1:0] rd_next;

  ts_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .tick_o(int_tick));

  ts_edge_sync #(.STAGES(2)) u_sync_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_clk_i), .rise_o(ext_tick));

  ts_edge_sync #(.STAGES(2)) u_sync_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_latch_i), .rise_o(ext_latch));

  ts_core #(.W(TS_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i),
    .int_tick_i(int_tick), .ext_tick_i(ext_tick), .ext_latch_i(ext_latch),
    .live_trig_i(live_trig_i), .veto_i(veto_i), .sel_i(sel_i),
    .snap_o(snap), .ts_clk_o(ts_clk_o), .ts_latch_o(ts_latch_o));

  // slice i sits at address i+1, low word first
  always_comb begin
    rd_next = '0;
    for (int i = 0; i < N_SLICE; i++) begin
      if (rd_addr_i == ADDR_W'(i + 1))
        rd_next = {{(RD_W - SLICE_W){1'b0}}, snap[i*SLICE_W +: SLICE_W]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= rd_next;
  end

  assert_rd_upper_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[RD_W-1:SLICE_W] == '0);
  assert_rd_unmapped_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_addr_i == '0) || (rd_addr_i > ADDR_W'(N_SLICE))) |=> (rd_data_o == '0));
endmodule

// File: tb/evt_timestamp_tb.sv
module evt_timestamp_tb;
  localparam time CLK_PERIOD = 25ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clear = 1'b0, ext_clk = 1'b0, ext_latch = 1'b0, veto = 1'b0, live = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [3:0] rd_addr = 4'd0;
  logic [23:0] rd_data;
  logic ts_clk, ts_latch;

  int total = 0, bad = 0;
  int clk_pulses = 0, latch_pulses = 0;
  logic [23:0] exp_q[$];
  string tag_q[$];
  logic [23:0] cur_exp;
  string cur_tag;
  bit cur_v = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_timestamp u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear), .ext_clk_i(ext_clk),
    .ext_latch_i(ext_latch), .veto_i(veto), .sel_i(sel), .live_trig_i(live),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .ts_clk_o(ts_clk), .ts_latch_o(ts_latch));

  // monitor: the item pushed before this edge is due at the next negedge
  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      cur_exp = exp_q.pop_front();
      cur_tag = tag_q.pop_front();
      cur_v = 1;
    end else cur_v = 0;
  end

  always @(negedge clk) begin
    if (ts_clk) clk_pulses++;
    if (ts_latch) latch_pulses++;
    if (cur_v) begin
      total++;
      if (rd_data !== cur_exp) begin
        bad++;
        $display("FAIL %s rd_data got=%h exp=%h", cur_tag, rd_data, cur_exp);
      end
    end
  end

  task automatic check_int(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic rd(string tag, logic [3:0] a, logic [15:0] e);
    @(negedge clk);
    rd_addr = a;
    exp_q.push_back({8'h00, e});
    tag_q.push_back(tag);
  endtask

  task automatic read_ts(string tag, logic [63:0] e);
    for (int i = 0; i < 4; i++) rd(tag, 4'(i + 1), e[i*16 +: 16]);
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_pulse();
    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0;
  endtask

  task automatic live_pulse();
    @(negedge clk); live = 1;
    @(negedge clk); live = 0;
  endtask

  task automatic ext_pulses(int n, int hi, int lo);
    for (int p = 0; p < n; p++) begin
      @(negedge clk); ext_clk = 1;
      repeat (hi - 1) @(negedge clk);
      @(negedge clk); ext_clk = 0;
      repeat (lo - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0, l0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R7 reset state, R6 unmapped addresses
    read_ts("R7 reset", 64'd0);
    rd("R6 addr0", 4'd0, 16'h0);
    rd("R6 addr5", 4'd5, 16'h0);
    repeat (3) @(negedge clk);

    // R1 internal tick: capture at e40 holds floor(39/4)=9
    clear_pulse();
    repeat (38) @(negedge clk);
    @(negedge clk); live = 1;
    @(negedge clk); live = 0;
    read_ts("R1 internal tick", 64'd9);

    // R2 veto over e1..e20, capture at e40 -> 4
    clear_pulse();
    veto = 1;
    repeat (20) @(negedge clk);
    veto = 0;
    repeat (18) @(negedge clk);
    @(negedge clk); live = 1;
    @(negedge clk); live = 0;
    read_ts("R2 veto", 64'd4);

    // R3 external clock, 7 pulses; R8 strobe count
    sel = 2'b01;
    clear_pulse();
    #1; c0 = clk_pulses; l0 = latch_pulses;
    ext_pulses(7, 3, 3);
    repeat (4) @(negedge clk);
    live_pulse();
    repeat (2) @(negedge clk);
    #1;
    check_int("R8 ts_clk_o pulses", clk_pulses - c0, 7);
    check_int("R8 ts_latch_o pulses", latch_pulses - l0, 1);
    read_ts("R3 external clock", 64'd7);

    // R4 external latch: live ignored, ext latch captures
    sel = 2'b11;
    clear_pulse();
    ext_pulses(3, 2, 2);
    live_pulse();
    repeat (3) @(negedge clk);
    read_ts("R4 live ignored", 64'd0);
    ext_pulses(2, 2, 2);
    repeat (4) @(negedge clk);
    @(negedge clk); ext_latch = 1;
    repeat (3) @(negedge clk);
    ext_latch = 0;
    repeat (4) @(negedge clk);
    read_ts("R4 external latch", 64'd5);
    // R5 snapshot holds while counting continues
    ext_pulses(2, 2, 2);
    repeat (4) @(negedge clk);
    read_ts("R5 hold", 64'd5);
    sel = 2'b01;
    live_pulse();
    repeat (2) @(negedge clk);
    read_ts("R4 internal latch", 64'd7);

    // R9 carry past 16 bits
    clear_pulse();
    ext_pulses(65537, 1, 1);
    repeat (4) @(negedge clk);
    live_pulse();
    repeat (2) @(negedge clk);
    read_ts("R9 carry", 64'h1_0001);

    // R7 clear zeroes snapshot
    clear_pulse();
    repeat (2) @(negedge clk);
    read_ts("R7 clear", 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule